// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block tracks the coherence state of each line in a small direct-mapped cache that sits on a shared snooping bus with peer caches. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The block takes read and write requests from its own processor and transactions snooped from the bus. It updates each line's state and issues bus requests when the processor access needs the bus. It also answers snoops with a shared indication and, when it holds the only up-to-date copy, with a flush of the line's data.

The processor holds `cpuValid` and its request fields steady until `cpuDone`. A hit that can complete locally finishes in the same cycle, and `cpuNoBus` flags that no bus transaction was used.

Any other access raises `busReqValid` with a command and address. The transaction takes place in the cycle where the external arbiter answers with `busGrant`. That cycle also carries the fill data and the other caches' shared indication. The arbiter never grants this cache in a cycle that carries a snooped transaction from a peer. Each line holds a single data word, standing in for the data array.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses. While idle, no bus request, flush or shared output is asserted.
- R2: A processor read that hits a line in Modified, Exclusive or Shared finishes in the same cycle with `cpuDone=1` and `cpuNoBus=1`. It returns the line's data, leaves the state unchanged and raises no bus request.
- R3: A processor write that hits a line in Exclusive or Modified finishes in the same cycle with `cpuNoBus=1` and makes no bus request. The line ends in Modified holding the write data.
- R4: A processor write that hits a Shared line requests BusUpgr (command code 2) at the processor address. On grant the line becomes Modified with the write data, and the access finishes with `cpuNoBus=0`.
- R5: A processor write that misses requests BusRdX (command code 1). On grant the line becomes Modified holding the write data, even when no peer holds the block.
- R6: A processor read that misses requests BusRd (command code 0). On grant the line is filled from `busDataIn` and that data is returned. The line fills as Exclusive when `busSharedIn` is low, and as Shared when it is high.
- R7: A snooped BusRd (code 0) that hits a valid line raises `snpShared` in the same cycle, and the line becomes Shared. If the line was Modified, `snpFlush` is also raised with the line data on `snpFlushData`. An Exclusive or Shared line supplies no data.
- R8: A snooped BusRdX (code 1) or BusUpgr (code 2) that hits a valid line makes it Invalid and does not raise `snpShared`. A Modified line hit by BusRdX is flushed with its data as it is invalidated.
- R9: A snooped write-back (code 3), or any snoop whose tag does not match a valid line, asserts no snoop output and changes no line.
- R10: A miss whose victim line is Modified first issues a write-back (code 3) carrying the victim's address (victim tag above the index) and its data. The fill request follows only after that. A clean or Invalid victim is replaced without any write-back.
- R11: If the Shared line of a pending write is invalidated by a snoop before the grant, the pending request changes from BusUpgr to BusRdX.
- R12: If a pending write-back's victim is flushed by a snooped BusRd before the grant, the write-back is dropped and the fill request proceeds.
- R13: The bus serialises transactions. A snoop and this cache's grant never share a cycle. A snoop that reaches the index of a processor hit in the same cycle takes effect first, and the processor access completes in a later cycle against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuValid | input | 1 | Processor request present, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor address, index in the low IDX_W bits |
| cpuWdata | input | DATA_W | Processor write data |
| cpuDone | output | 1 | Processor access completes this cycle |
| cpuNoBus | output | 1 | Completing access used no bus transaction |
| cpuRdata | output | DATA_W | Read data for a completing read |
| busReqValid | output | 1 | Bus transaction requested |
| busReqCmd | output | 2 | 0 BusRd, 1 BusRdX, 2 BusUpgr, 3 write-back |
| busReqAddr | output | ADDR_W | Address of the requested transaction |
| busReqData | output | DATA_W | Write-back data (zero for other commands) |
| busGrant | input | 1 | Requested transaction takes place this cycle |
| busDataIn | input | DATA_W | Fill data in the grant cycle |
| busSharedIn | input | 1 | A peer holds the block (sampled on grant) |
| snpValid | input | 1 | Peer transaction on the bus this cycle |
| snpCmd | input | 2 | Snooped command, same coding as busReqCmd |
| snpAddr | input | ADDR_W | Snooped address |
| snpShared | output | 1 | This cache holds the snooped block |
| snpFlush | output | 1 | This cache supplies the block's data |
| snpFlushData | output | DATA_W | Data supplied with snpFlush |

## Verification
A wrong line state always shows up at the ports. A processor access that should finish with `cpuNoBus=1` raises a bus request instead, or the reverse. A snoop gives the wrong `snpShared` or `snpFlush` answer in the same combinational cycle. The first access or snoop that touches the corrupted line exposes the fault. A wrong dirty state stays hidden until the line is snooped or evicted, where the write-back or flush is missing or extra. The races, where a snoop lands while a request waits for the grant or in the same cycle as a hit, show up as a wrong command code on the next granted transaction.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  // Line coherence states
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHD = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_t;

  // Bus command coding, shared by requests and snoops
  typedef enum logic [1:0] {
    BC_RD   = 2'd0,
    BC_RDX  = 2'd1,
    BC_UPGR = 2'd2,
    BC_WB   = 2'd3
  } busCmd_t;

  // Strobes from the control to the line table
  typedef struct packed {
    logic       wrHit;       // local write hit: store data, go Modified
    logic       fill;        // install line for the processor address
    lineState_t fillState;   // state given to the installed line
    logic       fillFromBus; // fill data comes from the bus, else from cpuWdata
    logic       evict;       // drop the victim after its write-back
  } lineStrobe_t;

endpackage

// File: rtl/mesi_line_table.sv
module mesi_line_table
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  lineStrobe_t       strobe,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              cpuHit,
  output lineState_t        cpuState,
  output logic [DATA_W-1:0] cpuData,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [DATA_W-1:0] victimData,
  output logic              snpConflict,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  lineState_t        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  logic [IDX_W-1:0]  cpuIdx, snpIdx;
  logic [TAG_W-1:0]  cpuTag, snpTag;
  busCmd_t           snpOp;
  logic [LINES-1:0]  snpHitVec;
  logic              snpHitAny;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];
  assign snpOp  = busCmd_t'(snpCmd);

  // Per-line snoop match
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      snpHitVec[i] = snpValid && (snpIdx == IDX_W'(i)) &&
                     (tagQ[i] == snpTag) && (stateQ[i] != LS_INV);
    end
  end
  assign snpHitAny = |snpHitVec;

  // Processor-side lookup
  assign cpuState    = stateQ[cpuIdx];
  assign cpuData     = dataQ[cpuIdx];
  assign cpuHit      = (stateQ[cpuIdx] != LS_INV) && (tagQ[cpuIdx] == cpuTag);
  assign victimDirty = (stateQ[cpuIdx] == LS_MOD) && (tagQ[cpuIdx] != cpuTag);
  assign victimAddr  = {tagQ[cpuIdx], cpuIdx};
  assign victimData  = dataQ[cpuIdx];
  assign snpConflict = snpValid && (snpIdx == cpuIdx);

  // Snoop responses
  assign snpShared    = snpHitAny && (snpOp == BC_RD);
  assign snpFlush     = snpHitAny && (stateQ[snpIdx] == LS_MOD) &&
                        ((snpOp == BC_RD) || (snpOp == BC_RDX));
  assign snpFlushData = dataQ[snpIdx];

  // State, tag and data update: a snoop on a line wins over local strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snpHitVec[i]) begin
          case (snpOp)
            BC_RD:           stateQ[i] <= LS_SHD;
            BC_RDX, BC_UPGR: stateQ[i] <= LS_INV;
            default:         ;
          endcase
        end else if (cpuIdx == IDX_W'(i)) begin
          if (strobe.evict) stateQ[i] <= LS_INV;
          if (strobe.wrHit) begin
            stateQ[i] <= LS_MOD;
            dataQ[i]  <= cpuWdata;
          end
          if (strobe.fill) begin
            tagQ[i]   <= cpuTag;
            stateQ[i] <= strobe.fillState;
            dataQ[i]  <= strobe.fillFromBus ? busDataIn : cpuWdata;
          end
        end
      end
    end
  end

  // Per-line snoop outcome checks
  for (genvar g = 0; g < LINES; g++) begin : g_chk
    p_snoop_rd_demote_r7: assert property (@(posedge clk) disable iff (!rstN)
      (snpHitVec[g] && snpOp == BC_RD) |=> (stateQ[g] == LS_SHD));
    p_snoop_kill_r8: assert property (@(posedge clk) disable iff (!rstN)
      (snpHitVec[g] && (snpOp == BC_RDX || snpOp == BC_UPGR)) |=> (stateQ[g] == LS_INV));
  end

  // A flush is always an answer to a reading snoop
  p_flush_on_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> (snpValid && snpOp != BC_WB && snpOp != BC_UPGR));

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuHit,
  input  lineState_t        cpuState,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              victimDirty,
  input  logic [ADDR_W-1:0] victimAddr,
  input  logic [DATA_W-1:0] victimData,
  input  logic              snpConflict,
  input  logic              busGrant,
  input  logic              busSharedIn,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              cpuDone,
  output logic              cpuNoBus,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output busCmd_t           busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  output lineStrobe_t       strobe
);

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WB   = 2'd1,
    CS_REQ  = 2'd2
  } ctrlState_t;

  ctrlState_t curQ, nxt;
  logic       fillRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curQ <= CS_IDLE;
    else       curQ <= nxt;
  end

  always_comb begin
    nxt         = curQ;
    cpuDone     = 1'b0;
    cpuNoBus    = 1'b0;
    busReqValid = 1'b0;
    busReqCmd   = BC_RD;
    busReqAddr  = cpuAddr;
    busReqData  = '0;
    strobe      = '0;
    fillRead    = 1'b0;
    case (curQ)
      CS_IDLE: begin
        if (cpuValid) begin
          if (cpuHit) begin
            if (!snpConflict) begin
              if (!cpuWrite) begin
                cpuDone  = 1'b1;
                cpuNoBus = 1'b1;
              end else if (cpuState == LS_EXC || cpuState == LS_MOD) begin
                cpuDone      = 1'b1;
                cpuNoBus     = 1'b1;
                strobe.wrHit = 1'b1;
              end else begin
                nxt = CS_REQ;
              end
            end
          end else begin
            nxt = victimDirty ? CS_WB : CS_REQ;
          end
        end
      end
      CS_WB: begin
        if (!victimDirty) begin
          nxt = CS_REQ;
        end else begin
          busReqValid = 1'b1;
          busReqCmd   = BC_WB;
          busReqAddr  = victimAddr;
          busReqData  = victimData;
          if (busGrant) begin
            strobe.evict = 1'b1;
            nxt          = CS_REQ;
          end
        end
      end
      CS_REQ: begin
        busReqValid = 1'b1;
        if (cpuWrite) busReqCmd = (cpuHit && cpuState == LS_SHD) ? BC_UPGR : BC_RDX;
        else          busReqCmd = BC_RD;
        if (busGrant) begin
          strobe.fill        = 1'b1;
          strobe.fillFromBus = !cpuWrite;
          strobe.fillState   = cpuWrite ? LS_MOD : (busSharedIn ? LS_SHD : LS_EXC);
          fillRead           = !cpuWrite;
          cpuDone            = 1'b1;
          nxt                = CS_IDLE;
        end
      end
      default: nxt = CS_IDLE;
    endcase
  end

  assign cpuRdata = fillRead ? busDataIn : cpuData;

  p_wb_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busReqCmd != BC_WB) |-> !victimDirty);

  p_local_no_bus_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuNoBus) |-> !busReqValid);

  p_fill_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busGrant && busReqCmd != BC_WB) |-> cpuDone);

  p_done_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuValid);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuDone,
  output logic              cpuNoBus,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReqValid,
  output logic [1:0]        busReqCmd,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [DATA_W-1:0] busReqData,
  input  logic              busGrant,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busSharedIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpFlushData
);

  lineStrobe_t       strobe;
  logic              cpuHit, victimDirty, snpConflict;
  lineState_t        cpuState;
  logic [DATA_W-1:0] cpuData, victimData;
  logic [ADDR_W-1:0] victimAddr;
  busCmd_t           reqCmd;

  mesi_line_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .busDataIn(busDataIn), .strobe(strobe),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .cpuHit(cpuHit), .cpuState(cpuState), .cpuData(cpuData),
    .victimDirty(victimDirty), .victimAddr(victimAddr), .victimData(victimData),
    .snpConflict(snpConflict), .snpShared(snpShared), .snpFlush(snpFlush),
    .snpFlushData(snpFlushData)
  );

  mesi_req_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuHit(cpuHit), .cpuState(cpuState), .cpuData(cpuData),
    .victimDirty(victimDirty), .victimAddr(victimAddr), .victimData(victimData),
    .snpConflict(snpConflict), .busGrant(busGrant), .busSharedIn(busSharedIn),
    .busDataIn(busDataIn),
    .cpuDone(cpuDone), .cpuNoBus(cpuNoBus), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqCmd(reqCmd), .busReqAddr(busReqAddr),
    .busReqData(busReqData), .strobe(strobe)
  );

  assign busReqCmd = reqCmd;

  // The arbiter serialises the bus: own grant and peer snoop never coincide
  p_grant_no_snoop_r13: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> !snpValid);

endmodule

// File: tb/test_mesi_line_ctrl.sv
module test_mesi_line_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic cpuDone, cpuNoBus;
  logic [DW-1:0] cpuRdata;
  logic busReqValid;
  logic [1:0] busReqCmd;
  logic [AW-1:0] busReqAddr;
  logic [DW-1:0] busReqData;
  logic busGrant = 1'b0;
  logic [DW-1:0] busDataIn = '0;
  logic busSharedIn = 1'b0;
  logic snpValid = 1'b0;
  logic [1:0] snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic snpShared, snpFlush;
  logic [DW-1:0] snpFlushData;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DATA_W(DW)) i_mesi_line_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuDone(cpuDone), .cpuNoBus(cpuNoBus), .cpuRdata(cpuRdata),
    .busReqValid(busReqValid), .busReqCmd(busReqCmd), .busReqAddr(busReqAddr),
    .busReqData(busReqData), .busGrant(busGrant), .busDataIn(busDataIn),
    .busSharedIn(busSharedIn), .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpShared(snpShared), .snpFlush(snpFlush), .snpFlushData(snpFlushData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard of expected processor completions
  typedef struct {
    bit          noBus;
    bit          chkData;
    logic [7:0]  data;
    string       req;
  } expItem_t;
  expItem_t expQ[$];
  expItem_t curItem;

  always @(negedge clk) begin
    if (rstN && cpuValid && cpuDone) begin
      if (expQ.size() == 0) begin
        checkEq("R2", "unexpected completion", 1, 0);
      end else begin
        curItem = expQ.pop_front();
        checkEq(curItem.req, "cpuNoBus", int'(cpuNoBus), int'(curItem.noBus));
        if (curItem.chkData) checkEq(curItem.req, "cpuRdata", int'(cpuRdata), int'(curItem.data));
      end
    end
  end

  // Granted transactions seen during the last access, and snoop answers
  int         txCount;
  logic [1:0] txCmd  [4];
  logic [7:0] txAddr [4];
  logic [7:0] txData [4];
  bit         sawSh, sawFl;
  logic [7:0] sawFd;

  task automatic access(input bit wr, input logic [7:0] addr, input logic [7:0] wd,
                        input int grantWait, input bit shIn, input logic [7:0] memData,
                        input bit expNoBus, input bit chkData, input logic [7:0] expData,
                        input string req, input int snpAt, input logic [1:0] sCmd,
                        input logic [7:0] sAddr);
    int  cyc = 0;
    int  waitCnt = 0;
    bit  sawReq = 0;
    bit  done = 0;
    expItem_t it;
    it.noBus = expNoBus; it.chkData = chkData; it.data = expData; it.req = req;
    expQ.push_back(it);
    txCount = 0;
    @(posedge clk); #1;
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    busDataIn = memData; busSharedIn = shIn;
    while (!done && cyc < 50) begin
      if (cyc == snpAt) begin
        snpValid = 1'b1; snpCmd = sCmd; snpAddr = sAddr; busGrant = 1'b0;
      end else begin
        snpValid = 1'b0;
        busGrant = sawReq && (waitCnt >= grantWait);
      end
      @(negedge clk);
      if (snpValid) begin
        sawSh = snpShared; sawFl = snpFlush; sawFd = snpFlushData;
      end
      if (busReqValid && busGrant) begin
        if (txCount < 4) begin
          txCmd[txCount] = busReqCmd; txAddr[txCount] = busReqAddr; txData[txCount] = busReqData;
        end
        txCount++;
        waitCnt = 0; sawReq = 0;
      end else if (busReqValid) begin
        waitCnt++; sawReq = 1;
      end else begin
        sawReq = 0;
      end
      if (cpuDone) done = 1;
      @(posedge clk); #1;
      cyc++;
    end
    cpuValid = 1'b0; busGrant = 1'b0; snpValid = 1'b0;
    if (!done) checkEq(req, "access completion", 0, 1);
  endtask

  task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr, input bit expSh,
                       input bit expFl, input bit chkFd, input logic [7:0] expFd, input string req);
    @(posedge clk); #1;
    snpValid = 1'b1; snpCmd = cmd; snpAddr = addr;
    @(negedge clk);
    checkEq(req, "snpShared", int'(snpShared), int'(expSh));
    checkEq(req, "snpFlush", int'(snpFlush), int'(expFl));
    if (chkFd) checkEq(req, "snpFlushData", int'(snpFlushData), int'(expFd));
    @(posedge clk); #1;
    snpValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog R1 run actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    checkEq("R1", "busReqValid idle", int'(busReqValid), 0);
    checkEq("R1", "snpShared idle", int'(snpShared), 0);
    checkEq("R1", "snpFlush idle", int'(snpFlush), 0);
    checkEq("R1", "cpuDone idle", int'(cpuDone), 0);

    // R1 / R6: first read misses, BusRd, fills Exclusive
    access(0, 8'h04, 8'h00, 1, 0, 8'hA1, 0, 1, 8'hA1, "R6", -1, 2'd0, 8'h00);
    checkEq("R1", "tx count first read", txCount, 1);
    checkEq("R6", "tx cmd BusRd", int'(txCmd[0]), 0);
    checkEq("R6", "tx addr", int'(txAddr[0]), 'h04);

    // R2: read hit
    access(0, 8'h04, 8'h00, 1, 0, 8'h00, 1, 1, 8'hA1, "R2", -1, 2'd0, 8'h00);
    checkEq("R2", "tx count read hit", txCount, 0);

    // R3: write to Exclusive is silent
    access(1, 8'h04, 8'h5B, 1, 0, 8'h00, 1, 0, 8'h00, "R3", -1, 2'd0, 8'h00);
    checkEq("R3", "tx count E write", txCount, 0);

    // R7: snooped BusRd on Modified flushes, then Shared answers without data
    snoop(2'd0, 8'h04, 1, 1, 1, 8'h5B, "R7");
    snoop(2'd0, 8'h04, 1, 0, 0, 8'h00, "R7");

    // R4: write to Shared uses BusUpgr
    access(1, 8'h04, 8'h6C, 1, 0, 8'h00, 0, 0, 8'h00, "R4", -1, 2'd0, 8'h00);
    checkEq("R4", "tx count", txCount, 1);
    checkEq("R4", "tx cmd BusUpgr", int'(txCmd[0]), 2);
    checkEq("R4", "tx addr", int'(txAddr[0]), 'h04);

    // R8: snooped BusRdX on Modified flushes and invalidates
    snoop(2'd1, 8'h04, 0, 1, 1, 8'h6C, "R8");
    // R6: read miss with sharer fills Shared
    access(0, 8'h04, 8'h00, 1, 1, 8'h77, 0, 1, 8'h77, "R6", -1, 2'd0, 8'h00);
    checkEq("R8", "tx count after invalidate", txCount, 1);
    // R8: snooped BusUpgr invalidates Shared silently
    snoop(2'd2, 8'h04, 0, 0, 0, 8'h00, "R8");
    access(0, 8'h04, 8'h00, 1, 0, 8'h31, 0, 1, 8'h31, "R8", -1, 2'd0, 8'h00);
    checkEq("R8", "tx count after upgrade snoop", txCount, 1);

    // R9: snooped write-back and tag miss have no effect
    snoop(2'd3, 8'h04, 0, 0, 0, 8'h00, "R9");
    access(1, 8'h04, 8'h42, 1, 0, 8'h00, 1, 0, 8'h00, "R9", -1, 2'd0, 8'h00);
    checkEq("R9", "tx count still Exclusive", txCount, 0);
    snoop(2'd0, 8'h08, 0, 0, 0, 8'h00, "R9");

    // R10: dirty victim written back before the fill
    access(0, 8'h08, 8'h00, 1, 0, 8'h90, 0, 1, 8'h90, "R10", -1, 2'd0, 8'h00);
    checkEq("R10", "tx count dirty evict", txCount, 2);
    checkEq("R10", "wb cmd", int'(txCmd[0]), 3);
    checkEq("R10", "wb addr", int'(txAddr[0]), 'h04);
    checkEq("R10", "wb data", int'(txData[0]), 'h42);
    checkEq("R10", "fill cmd", int'(txCmd[1]), 0);
    checkEq("R10", "fill addr", int'(txAddr[1]), 'h08);
    // R10: clean victim replaced silently
    access(0, 8'h0C, 8'h00, 1, 1, 8'h11, 0, 1, 8'h11, "R10", -1, 2'd0, 8'h00);
    checkEq("R10", "tx count clean evict", txCount, 1);
    checkEq("R10", "clean fill addr", int'(txAddr[0]), 'h0C);

    // R11: pending upgrade loses its Shared copy, becomes BusRdX
    access(1, 8'h0C, 8'h22, 3, 0, 8'h00, 0, 0, 8'h00, "R11", 2, 2'd2, 8'h0C);
    checkEq("R11", "tx count", txCount, 1);
    checkEq("R11", "tx cmd BusRdX", int'(txCmd[0]), 1);
    access(0, 8'h0C, 8'h00, 1, 0, 8'h00, 1, 1, 8'h22, "R11", -1, 2'd0, 8'h00);

    // R5: write miss without sharers still uses BusRdX and ends Modified
    access(1, 8'h01, 8'h33, 1, 0, 8'hEE, 0, 0, 8'h00, "R5", -1, 2'd0, 8'h00);
    checkEq("R5", "tx cmd BusRdX", int'(txCmd[0]), 1);
    checkEq("R5", "tx addr", int'(txAddr[0]), 'h01);
    access(0, 8'h01, 8'h00, 1, 0, 8'h00, 1, 1, 8'h33, "R5", -1, 2'd0, 8'h00);
    snoop(2'd0, 8'h01, 1, 1, 1, 8'h33, "R5");

    // R12: pending write-back cancelled by a flushing snoop
    access(1, 8'h02, 8'h44, 1, 0, 8'h00, 0, 0, 8'h00, "R12", -1, 2'd0, 8'h00);
    access(0, 8'h06, 8'h00, 3, 0, 8'h55, 0, 1, 8'h55, "R12", 2, 2'd0, 8'h02);
    checkEq("R12", "snoop flush while pending", int'(sawFl), 1);
    checkEq("R12", "snoop flush data", int'(sawFd), 'h44);
    checkEq("R12", "tx count no write-back", txCount, 1);
    checkEq("R12", "tx cmd BusRd", int'(txCmd[0]), 0);
    checkEq("R12", "tx addr", int'(txAddr[0]), 'h06);

    // R13: snoop to the same index as a local write hit is applied first
    access(1, 8'h06, 8'h66, 1, 0, 8'h00, 0, 0, 8'h00, "R13", 0, 2'd0, 8'h06);
    checkEq("R13", "snoop saw Exclusive shared", int'(sawSh), 1);
    checkEq("R13", "snoop no flush", int'(sawFl), 0);
    checkEq("R13", "tx count", txCount, 1);
    checkEq("R13", "tx cmd BusUpgr", int'(txCmd[0]), 2);
    access(0, 8'h06, 8'h00, 1, 0, 8'h00, 1, 1, 8'h66, "R13", -1, 2'd0, 8'h00);

    repeat (2) @(posedge clk);
    checkEq("R2", "scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule